// File: doc/BRIEF.md
# Parallel Scrambling NRZI Line Encoder

This block is the transmit-side line encoder for a high-definition serial digital video link. On every clock where the enable is high, it accepts one 20-bit parallel word. It treats the word as the next 20 bits of one continuous serial stream. Bit 0 is the earliest bit in serial time and bit 19 is the latest. Word and character boundaries play no part in the coding.

The stream first passes through a self-synchronising scrambler with generator x^9 + x^4 + 1. It is then mapped to polarity-free NRZI with generator x + 1. Both feedback chains are unrolled across the 20 bit positions inside one cycle. The scrambler history and the last line bit are carried from one word to the next. The encoded word is registered, so it appears one enabled clock after its input. A receiver undoes the two steps in the reverse order: first NRZI to NRZ, then descrambling.

Top module: `serial_link_encoder`

## Requirements
- R1: An active-high asynchronous reset clears the output word and all coding state to zero at once, without waiting for a clock edge.
- R2: On a clock edge where `ce` is low, the output and all coding state keep their values, whatever `din` carries.
- R3: The scrambled bit is computed as s[n] = d[n] ^ s[n-4] ^ s[n-9], where n counts serial bits and `din[0]` is the earliest bit of a word. The history used for the low bits of a word comes from the previous enabled word, also across gaps where `ce` was low.
- R4: The line bit is computed as o[n] = s[n] ^ o[n-1]. For bit 0 of a word, o[n-1] is bit 19 of the previously encoded word.
- R5: The encoded word for an input appears on `dout` after the enabled clock edge that samples that input, and not before it.
- R6: When the state is cleared and the input is all zeros, the output stays all zeros. From cleared state, the input 20'h00001 encodes to 20'h2F10F.
- R7: A receiver applies NRZI-to-NRZ conversion and then the x^9 + x^4 + 1 descrambler. Starting from arbitrary state, that receiver recovers the original bits exactly once its first 10 serial bits have passed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| ce | input | 1 | Clock enable; the word is taken and state advances only when high |
| din | input | 20 | Parallel input word; bit 0 earliest in serial time |
| dout | output | 20 | Registered encoded word; bit 0 earliest in serial time |

## Verification
The clocked properties take for granted that `ce` and `din` are settled, known values at each rising edge. They also assume reset is applied before the first check, which is why every property is disabled while `rst` is high. The stimulus therefore changes inputs only two nanoseconds after a rising edge. It pulses reset between edges, and it compares the output against a bit-serial reference encoder. Separately, an independent bit-serial decoder, started from arbitrary state, confirms that the original stream is recovered.

// File: rtl/sle_pkg.sv
package sle_pkg;
    // Default geometry of the encoder: word width and scrambler tap distances.
    localparam int unsigned SLE_WORD_W   = 20;
    localparam int unsigned SLE_TAP_NEAR = 4;
    localparam int unsigned SLE_TAP_FAR  = 9;
endpackage

// File: rtl/sle_scramble_chain.sv
module sle_scramble_chain #(
    parameter int unsigned WORD_W   = sle_pkg::SLE_WORD_W,
    parameter int unsigned TAP_NEAR = sle_pkg::SLE_TAP_NEAR,
    parameter int unsigned TAP_FAR  = sle_pkg::SLE_TAP_FAR
) (
    input  logic [WORD_W-1:0]  plain_i,
    input  logic [TAP_FAR-1:0] hist_i,   // bit 0 earliest, top bit latest
    output logic [WORD_W-1:0]  scr_o,
    output logic [TAP_FAR-1:0] hist_o
);
    localparam int unsigned EXT_W = WORD_W + TAP_FAR;

    // Unrolled feedback: each new scrambled bit sees the ones formed before it.
    always_comb begin : chain
        logic [EXT_W-1:0] ext_v;
        ext_v = '0;
        ext_v[TAP_FAR-1:0] = hist_i;
        for (int i = 0; i < int'(WORD_W); i++) begin
            ext_v[i+TAP_FAR] = plain_i[i]
                             ^ ext_v[i+TAP_FAR-TAP_NEAR]
                             ^ ext_v[i];
        end
        scr_o  = ext_v[EXT_W-1:TAP_FAR];
        hist_o = ext_v[EXT_W-1 -: TAP_FAR];
    end
endmodule

// File: rtl/sle_nrzi_chain.sv
module sle_nrzi_chain #(
    parameter int unsigned WORD_W = sle_pkg::SLE_WORD_W
) (
    input  logic [WORD_W-1:0] scr_i,
    input  logic              prev_i,   // last line bit of the previous word
    output logic [WORD_W-1:0] line_o
);
    // Running parity: every line bit toggles when its scrambled bit is one.
    always_comb begin : chain
        logic run_v;
        run_v  = prev_i;
        line_o = '0;
        for (int i = 0; i < int'(WORD_W); i++) begin
            run_v     = run_v ^ scr_i[i];
            line_o[i] = run_v;
        end
    end
endmodule

// File: rtl/serial_link_encoder.sv
module serial_link_encoder #(
    parameter int unsigned WORD_W   = sle_pkg::SLE_WORD_W,
    parameter int unsigned TAP_NEAR = sle_pkg::SLE_TAP_NEAR,
    parameter int unsigned TAP_FAR  = sle_pkg::SLE_TAP_FAR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout
);
    typedef struct packed {
        logic [TAP_FAR-1:0] hist;   // last scrambled bits, bit 0 earliest
        logic [WORD_W-1:0]  line;   // registered encoded word
    } enc_state_t;

    enc_state_t         st_d, st_q;
    logic [WORD_W-1:0]  scr_word_d;
    logic [TAP_FAR-1:0] hist_next_d;
    logic [WORD_W-1:0]  line_next_d;

    sle_scramble_chain #(
        .WORD_W  (WORD_W),
        .TAP_NEAR(TAP_NEAR),
        .TAP_FAR (TAP_FAR)
    ) scr_i (
        .plain_i(din),
        .hist_i (st_q.hist),
        .scr_o  (scr_word_d),
        .hist_o (hist_next_d)
    );

    sle_nrzi_chain #(
        .WORD_W(WORD_W)
    ) nrzi_i (
        .scr_i (scr_word_d),
        .prev_i(st_q.line[WORD_W-1]),
        .line_o(line_next_d)
    );

    always_comb begin
        st_d = st_q;
        if (ce) begin
            st_d.hist = hist_next_d;
            st_d.line = line_next_d;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign dout = st_q.line;

    // Disabled edge leaves everything untouched.
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !ce |=> ($stable(dout) && $stable(st_q.hist)));

    // Undoing the line coding of the new word yields the scrambled word taken.
    p_nrzi_inverse_r4: assert property (@(posedge clk) disable iff (rst)
        ce |=> ((dout ^ {dout[WORD_W-2:0], $past(dout[WORD_W-1])})
                == $past(scr_word_d)));

    // Idle cleared state stays idle.
    p_zero_fixed_r6: assert property (@(posedge clk) disable iff (rst)
        (ce && din == '0 && st_q.hist == '0 && dout[WORD_W-1] == 1'b0)
        |=> (dout == '0));

    generate
        if (WORD_W >= TAP_FAR) begin : g_hist_chk
            // History follows the latest scrambled bits of each enabled word.
            p_hist_track_r3: assert property (@(posedge clk) disable iff (rst)
                ce |=> (st_q.hist == $past(scr_word_d[WORD_W-1 -: TAP_FAR])));
        end
    endgenerate
endmodule

// File: tb/serial_link_encoder_tb_top.sv
`timescale 1ns/1ps
module serial_link_encoder_tb_top;
    localparam int W = 20;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ce  = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] dout;

    int errors = 0;
    int checks = 0;

    // Bit-serial reference encoder state: m_hist[0] is the most recent bit.
    logic [8:0]   m_hist = '0;
    logic         m_last = 1'b0;
    logic [W-1:0] m_out  = '0;

    always #4 clk = ~clk;

    serial_link_encoder dut_i (
        .clk (clk),
        .rst (rst),
        .ce  (ce),
        .din (din),
        .dout(dout)
    );

    typedef struct packed {
        logic [W-1:0] data;
        logic [W-1:0] want;
        logic         hand;   // 1: compare against want, 0: against model
    } vec_t;

    localparam vec_t VECS [0:9] = '{
        '{20'h00000, 20'h00000, 1'b1},
        '{20'h00001, 20'h2F10F, 1'b1},
        '{20'hFFFFF, 20'h00000, 1'b0},
        '{20'hAAAAA, 20'h00000, 1'b0},
        '{20'h55555, 20'h00000, 1'b0},
        '{20'h00000, 20'h00000, 1'b0},
        '{20'h3FF00, 20'h00000, 1'b0},
        '{20'h80001, 20'h00000, 1'b0},
        '{20'h12345, 20'h00000, 1'b0},
        '{20'hFEDCB, 20'h00000, 1'b0}
    };

    task automatic check(input string tag, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%05h expected=%05h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_hist = '0;
        m_last = 1'b0;
        m_out  = '0;
    endtask

    task automatic model_step(input logic [W-1:0] d);
        for (int i = 0; i < W; i++) begin
            logic s;
            s      = d[i] ^ m_hist[3] ^ m_hist[8];
            m_hist = {m_hist[7:0], s};
            m_last = s ^ m_last;
            m_out[i] = m_last;
        end
    endtask

    // Drive two ns after an edge, step the model, wait for the next edge + 2 ns.
    task automatic apply(input logic ce_v, input logic [W-1:0] d_v);
        ce  = ce_v;
        din = d_v;
        if (ce_v) model_step(d_v);
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        #2;
        rst = 1'b0;
        model_reset();
    endtask

    initial begin : watchdog
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [W-1:0] held;
        logic [8:0]   dh;
        logic         dprev;
        logic [W-1:0] dec;

        do_reset();
        check("R1 reset output", dout, 20'h00000);

        // Vector table: hand values first, then the bit-serial model.
        foreach (VECS[k]) begin
            apply(1'b1, VECS[k].data);
            if (VECS[k].hand) check("R6 table hand vector", dout, VECS[k].want);
            else              check("R3 R4 table vector", dout, m_out);
        end

        // R2: disabled edges with changing data leave the output alone.
        held = dout;
        apply(1'b0, 20'hFFFFF);
        check("R2 hold ce low", dout, held);
        apply(1'b0, 20'h0F0F0);
        check("R2 hold ce low again", dout, held);
        // R3: state carried across the gap.
        apply(1'b1, 20'h13579);
        check("R3 resume after gap", dout, m_out);

        // R5: a new input does not reach the output before the edge.
        held = dout;
        ce  = 1'b1;
        din = 20'hC0FFE;
        #1;
        check("R5 no change before edge", dout, held);
        model_step(20'hC0FFE);
        @(posedge clk);
        #2;
        check("R5 word after one enabled edge", dout, m_out);

        // R1: asynchronous reset in mid-cycle.
        ce  = 1'b0;
        rst = 1'b1;
        #1;
        check("R1 async clear", dout, 20'h00000);
        @(posedge clk);
        #2;
        rst = 1'b0;
        model_reset();
        apply(1'b1, 20'h00001);
        check("R1 state cleared, known word", dout, 20'h2F10F);

        // R6: zeros from cleared state stay zero.
        do_reset();
        for (int k = 0; k < 3; k++) begin
            apply(1'b1, 20'h00000);
            check("R6 zero in zero out", dout, 20'h00000);
        end

        // R3/R4: random words with random enable gaps against the serial model.
        for (int k = 0; k < 200; k++) begin
            logic ce_r;
            ce_r = ($urandom % 4) != 0;
            apply(ce_r, W'($urandom));
            check("R3 R4 random stream", dout, m_out);
        end

        // R7: independent receiver from arbitrary state recovers the data.
        do_reset();
        dh    = 9'h1FF;
        dprev = 1'b1;
        for (int k = 0; k < 100; k++) begin
            logic [W-1:0] word;
            word = W'($urandom);
            apply(1'b1, word);
            for (int i = 0; i < W; i++) begin
                logic n;
                n      = dout[i] ^ dprev;
                dprev  = dout[i];
                dec[i] = n ^ dh[3] ^ dh[8];
                dh     = {dh[7:0], n};
            end
            if (k > 0) check("R7 round trip recovery", dec, word);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule